// File: doc/BRIEF.md
# Circuit-Switched Tile Routing Switch

This block is the routing switch that sits beside each processor tile in a two-dimensional mesh. It joins eight incoming neighbour links, eight outgoing neighbour links and the local core. The links form two independent layers, and each layer has one link towards each of the four compass directions. The core has two outgoing streams into the switch and two incoming streams out of it. A configuration register, loaded once while the links are idle, fixes which source drives each outgoing link and which incoming link feeds each core input. After that, words flow with no header and do not involve any core they pass through.

Every link carries a data word with a valid strobe forward and a ready (request) strobe backward. A word moves only in a cycle where both strobes are high. A bit mask chooses, per outgoing link, between a plain combinational pass-through and a two-entry registered stage. The registered stage lets a long route cross many tiles while backpressure still works and the route still carries one word per cycle.

Top module: `tile_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, the configuration is all zeros, every outgoing link and both core inputs show valid low, and every incoming link and both core streams see ready low.
- R2: Each outgoing link k (k = layer*4 + direction, direction N=0, E=1, S=2, W=3) has a 3-bit select at configuration bits [3k+2:3k]. Codes 1 to 4 take the incoming link of the same layer from direction N, E, S, W. Codes 5 and 6 take core stream 0 and 1. Codes 0 and 7 leave the link off, with its valid held low.
- R3: Core input r has a 4-bit select at configuration bits [24+4r+3:24+4r]. Bit 3 enables it and bits 2:0 give the incoming link index. When it is disabled, that core input shows valid low.
- R4: On an outgoing link without a pipeline stage, and on both core inputs, valid and data of the selected source appear in the same cycle, and that link's ready is returned to the source in the same cycle.
- R5: On an outgoing link whose PIPE_MASK bit is set, each accepted word appears no earlier than the cycle after it was accepted. Words keep their order and none is lost or duplicated under any backpressure, and at most two words are held in the stage.
- R6: With the source always valid and the sink always ready, every configured route, with or without a stage, delivers one word per clock cycle.
- R7: An incoming link or core stream that no output or core input selects sees ready low, so nothing it offers is taken.
- R8: A word transfers only when valid and ready are both high. A registered output that shows valid without ready keeps valid high and its data unchanged in the next cycle.
- R9: A configuration word presented with cfg_load takes effect from the cycle after the clock edge that samples cfg_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the route configuration |
| cfg_word | input | 32 | Route configuration (output selects, core input selects) |
| lin_data | input | 8 x DW | Incoming neighbour link data, index layer*4+direction |
| lin_valid | input | 8 | Incoming link valid |
| lin_ready | output | 8 | Ready returned to incoming links |
| lout_data | output | 8 x DW | Outgoing neighbour link data |
| lout_valid | output | 8 | Outgoing link valid |
| lout_ready | input | 8 | Ready from outgoing link sinks |
| core_tx_data | input | 2 x DW | Core stream data into the switch |
| core_tx_valid | input | 2 | Core stream valid |
| core_tx_ready | output | 2 | Ready returned to the core streams |
| core_rx_data | output | 2 x DW | Data delivered to the core inputs |
| core_rx_valid | output | 2 | Core input valid |
| core_rx_ready | input | 2 | Ready from the core inputs |

## Verification
Unstaged routes and core inputs are due in the same cycle as their source, and staged routes one cycle or more after acceptance. A configuration load is due the cycle after its edge. The bench drives inputs just after the falling edge and samples one nanosecond before the rising edge, so each comparison sees exactly the values the next edge acts on. A behavioural model keeps one queue per destination: it pushes each word when the source handshake occurs and pops it at the destination handshake. On unstaged routes it also compares valid and ready with the source every cycle. On staged routes it checks that valid never appears before a word was queued in an earlier cycle, and that no more than two words are in flight.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
package tsw_pkg;
   localparam int NDIR    = 4;
   localparam int NLAYER  = 2;
   localparam int NLINK   = NDIR * NLAYER;
   localparam int NCORE   = 2;
   localparam int OSELW   = 3;
   localparam int CSELW   = 4;
   localparam int CFGW    = NLINK * OSELW + NCORE * CSELW;
   localparam int CSEL_LO = NLINK * OSELW;
   localparam int NCAND   = NDIR + NCORE;

   typedef enum logic [OSELW-1:0] {
      OSEL_OFF   = 3'd0,
      OSEL_NORTH = 3'd1,
      OSEL_EAST  = 3'd2,
      OSEL_SOUTH = 3'd3,
      OSEL_WEST  = 3'd4,
      OSEL_CORE0 = 3'd5,
      OSEL_CORE1 = 3'd6,
      OSEL_OFF7  = 3'd7
   } osel_e;
endpackage

// File: rtl/tsw_cfg_reg.sv
`timescale 1ns/1ps
module tsw_cfg_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("tsw_cfg_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (load) q <= wdata;
   end

   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(wdata)));
endmodule

// File: rtl/tsw_skid.sv
`timescale 1ns/1ps
module tsw_skid #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          in_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          out_ready
);
   if (DW < 1) begin : g_bad_dw
      $error("tsw_skid: DW must be at least 1");
   end

   logic [1:0]    fill;
   logic [DW-1:0] head;
   logic [DW-1:0] spare;
   logic          push;
   logic          pop;

   assign in_ready  = (fill != 2'd2);
   assign out_valid = (fill != 2'd0);
   assign out_data  = head;
   assign push      = in_valid && in_ready;
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill  <= 2'd0;
         head  <= '0;
         spare <= '0;
      end else begin
         if (push && !pop) begin
            if (fill == 2'd0) head <= in_data;
            else spare <= in_data;
            fill <= fill + 2'd1;
         end else if (pop && !push) begin
            head <= spare;
            fill <= fill - 2'd1;
         end else if (push && pop) begin
            if (fill == 2'd1) begin
               head <= in_data;
            end else begin
               head  <= spare;
               spare <= in_data;
            end
         end
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !out_ready) |=> out_valid);

   assert_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready) |-> out_valid);
endmodule

// File: rtl/tsw_out_port.sv
`timescale 1ns/1ps
module tsw_out_port
   import tsw_pkg::*;
#(
   parameter int DW    = 16,
   parameter bit PIPED = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [OSELW-1:0]           sel,
   input  logic [NCAND-1:0]           cand_valid,
   input  logic [NCAND-1:0][DW-1:0]   cand_data,
   output logic                       up_ready,
   output logic                       dn_valid,
   output logic [DW-1:0]              dn_data,
   input  logic                       dn_ready
);
   logic          pick_valid;
   logic [DW-1:0] pick_data;
   logic [OSELW-1:0] idx;
   logic          sel_on;

   assign sel_on = (sel != OSEL_OFF) && (sel != OSEL_OFF7);
   assign idx    = sel - 3'd1;

   always_comb begin
      pick_valid = 1'b0;
      pick_data  = '0;
      if (sel_on) begin
         pick_valid = cand_valid[idx];
         pick_data  = cand_data[idx];
      end
   end

   if (PIPED) begin : g_stage
      logic stage_ready;
      tsw_skid #(.DW(DW)) u_skid (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (pick_valid),
         .in_data   (pick_data),
         .in_ready  (stage_ready),
         .out_valid (dn_valid),
         .out_data  (dn_data),
         .out_ready (dn_ready)
      );
      assign up_ready = stage_ready && sel_on;
   end else begin : g_wire
      assign dn_valid = pick_valid;
      assign dn_data  = pick_data;
      assign up_ready = dn_ready && sel_on;
   end
endmodule

// File: rtl/tsw_core_sel.sv
`timescale 1ns/1ps
module tsw_core_sel
   import tsw_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [CSELW-1:0]         csel,
   input  logic [NLINK-1:0]         lin_valid,
   input  logic [NLINK-1:0][DW-1:0] lin_data,
   output logic                     rx_valid,
   output logic [DW-1:0]            rx_data
);
   logic [2:0] src;
   logic       en;

   assign en  = csel[3];
   assign src = csel[2:0];

   always_comb begin
      rx_valid = 1'b0;
      rx_data  = '0;
      if (en) begin
         rx_valid = lin_valid[src];
         rx_data  = lin_data[src];
      end
   end
endmodule

// File: rtl/tile_switch.sv
`timescale 1ns/1ps
module tile_switch
   import tsw_pkg::*;
#(
   parameter int               DW        = 16,
   parameter logic [NLINK-1:0] PIPE_MASK = 8'hF0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_load,
   input  logic [CFGW-1:0]          cfg_word,
   input  logic [NLINK-1:0][DW-1:0] lin_data,
   input  logic [NLINK-1:0]         lin_valid,
   output logic [NLINK-1:0]         lin_ready,
   output logic [NLINK-1:0][DW-1:0] lout_data,
   output logic [NLINK-1:0]         lout_valid,
   input  logic [NLINK-1:0]         lout_ready,
   input  logic [NCORE-1:0][DW-1:0] core_tx_data,
   input  logic [NCORE-1:0]         core_tx_valid,
   output logic [NCORE-1:0]         core_tx_ready,
   output logic [NCORE-1:0][DW-1:0] core_rx_data,
   output logic [NCORE-1:0]         core_rx_valid,
   input  logic [NCORE-1:0]         core_rx_ready
);
   if (DW < 1) begin : g_bad_dw
      $error("tile_switch: DW must be at least 1");
   end
   if (NCORE != 2 || NDIR != 4) begin : g_bad_geom
      $error("tile_switch: select codes assume four directions and two core streams");
   end

   logic [CFGW-1:0]         cfg_q;
   logic [NLINK-1:0]        up_ready;
   logic [OSELW-1:0]        osel [NLINK];
   logic [CSELW-1:0]        csel [NCORE];

   tsw_cfg_reg #(.W(CFGW)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cfg_load),
      .wdata (cfg_word),
      .q     (cfg_q)
   );

   for (genvar k = 0; k < NLINK; k++) begin : g_out
      localparam int LAY = k / NDIR;
      logic [NCAND-1:0]         cv;
      logic [NCAND-1:0][DW-1:0] cd;

      assign osel[k] = cfg_q[k*OSELW +: OSELW];
      assign cv      = {core_tx_valid, lin_valid[LAY*NDIR +: NDIR]};
      assign cd      = {core_tx_data, lin_data[LAY*NDIR +: NDIR]};

      tsw_out_port #(.DW(DW), .PIPED(PIPE_MASK[k])) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel        (osel[k]),
         .cand_valid (cv),
         .cand_data  (cd),
         .up_ready   (up_ready[k]),
         .dn_valid   (lout_valid[k]),
         .dn_data    (lout_data[k]),
         .dn_ready   (lout_ready[k])
      );

      assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ((osel[k] == OSEL_OFF) || (osel[k] == OSEL_OFF7)) |-> !lout_valid[k]);
   end

   for (genvar r = 0; r < NCORE; r++) begin : g_rx
      assign csel[r] = cfg_q[CSEL_LO + r*CSELW +: CSELW];

      tsw_core_sel #(.DW(DW)) u_sel (
         .csel      (csel[r]),
         .lin_valid (lin_valid),
         .lin_data  (lin_data),
         .rx_valid  (core_rx_valid[r]),
         .rx_data   (core_rx_data[r])
      );

      assert_rxoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !csel[r][3] |-> !core_rx_valid[r]);
   end

   // Backward ready: each source collects the ready of whoever selected it.
   always_comb begin
      logic [2:0] li;
      lin_ready     = '0;
      core_tx_ready = '0;
      for (int k = 0; k < NLINK; k++) begin
         li = 3'((k / NDIR) * NDIR) + osel[k] - 3'd1;
         if (osel[k] >= OSEL_NORTH && osel[k] <= OSEL_WEST)
            lin_ready[li] = lin_ready[li] | up_ready[k];
         if (osel[k] == OSEL_CORE0)
            core_tx_ready[0] = core_tx_ready[0] | up_ready[k];
         if (osel[k] == OSEL_CORE1)
            core_tx_ready[1] = core_tx_ready[1] | up_ready[k];
      end
      for (int r = 0; r < NCORE; r++) begin
         if (csel[r][3])
            lin_ready[csel[r][2:0]] = lin_ready[csel[r][2:0]] | core_rx_ready[r];
      end
   end

   assert_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q == '0) |-> (lin_ready == '0 && core_tx_ready == '0));
endmodule

// File: tb/tile_switch_tb.sv
`timescale 1ns/1ps
module tile_switch_tb;
   localparam int DW = 16;
   localparam logic [7:0] PMASK = 8'hF0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [31:0] cfg_word = '0;
   logic [7:0][DW-1:0] lin_data = '0;
   logic [7:0] lin_valid = '0;
   logic [7:0] lin_ready;
   logic [7:0][DW-1:0] lout_data;
   logic [7:0] lout_valid;
   logic [7:0] lout_ready = '0;
   logic [1:0][DW-1:0] core_tx_data = '0;
   logic [1:0] core_tx_valid = '0;
   logic [1:0] core_tx_ready;
   logic [1:0][DW-1:0] core_rx_data;
   logic [1:0] core_rx_valid;
   logic [1:0] core_rx_ready = '0;

   always #2 clk = ~clk;

   tile_switch #(.DW(DW), .PIPE_MASK(PMASK)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
      .lin_data(lin_data), .lin_valid(lin_valid), .lin_ready(lin_ready),
      .lout_data(lout_data), .lout_valid(lout_valid), .lout_ready(lout_ready),
      .core_tx_data(core_tx_data), .core_tx_valid(core_tx_valid),
      .core_tx_ready(core_tx_ready), .core_rx_data(core_rx_data),
      .core_rx_valid(core_rx_valid), .core_rx_ready(core_rx_ready));

   // ids 0..7 links, 8..9 core streams (sources) / core inputs (destinations)
   logic [DW-1:0] q [10][$];
   int route_src [10];
   int route_dst [10];
   int next_src  [10];
   logic [31:0] pend_cfg;
   bit sv [10];
   logic [DW-1:0] sd [10];
   bit rr [10];
   bit acc [10];
   int seq [10];
   int qpre [10];
   int tp_count [10];
   bit tp_on;
   int vp, rp;
   int errors = 0;
   int checks = 0;
   bit finished = 0;

   function automatic bit src_r(int s);
      return (s < 8) ? lin_ready[s] : core_tx_ready[s-8];
   endfunction
   function automatic bit dst_v(int d);
      return (d < 8) ? lout_valid[d] : core_rx_valid[d-8];
   endfunction
   function automatic logic [DW-1:0] dst_d(int d);
      return (d < 8) ? lout_data[d] : core_rx_data[d-8];
   endfunction
   function automatic bit draw(int p);
      return $urandom_range(0, 99) < p;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic drive();
      for (int s = 0; s < 10; s++) begin
         if (acc[s] || !sv[s]) begin
            if (acc[s]) seq[s]++;
            sv[s] = draw(vp);
            sd[s] = {s[3:0], seq[s][11:0]};
         end
         acc[s] = 0;
      end
      for (int d = 0; d < 10; d++) rr[d] = draw(rp);
      for (int i = 0; i < 8; i++) begin
         lin_valid[i] = sv[i];
         lin_data[i]  = sd[i];
         lout_ready[i] = rr[i];
      end
      for (int c = 0; c < 2; c++) begin
         core_tx_valid[c] = sv[8+c];
         core_tx_data[c]  = sd[8+c];
         core_rx_ready[c] = rr[8+c];
      end
   endtask

   task automatic sample();
      for (int d = 0; d < 10; d++) qpre[d] = q[d].size();
      for (int s = 0; s < 10; s++) begin
         acc[s] = sv[s] && src_r(s);
         if (route_dst[s] < 0)
            chk(src_r(s) == 1'b0, "R7", 32'(src_r(s)), 0, $sformatf("unrouted source %0d ready", s));
         else if (acc[s])
            q[route_dst[s]].push_back(sd[s]);
      end
      for (int d = 0; d < 10; d++) begin
         int rs;
         bit unp;
         rs  = route_src[d];
         unp = (d >= 8) || !PMASK[d];
         if (rs < 0) begin
            chk(dst_v(d) == 1'b0, (d < 8) ? "R2" : "R3", 32'(dst_v(d)), 0,
                $sformatf("idle destination %0d valid", d));
         end else begin
            if (unp) begin
               chk(dst_v(d) == sv[rs], "R4", 32'(dst_v(d)), 32'(sv[rs]), $sformatf("dest %0d valid", d));
               chk(src_r(rs) == rr[d], "R4", 32'(src_r(rs)), 32'(rr[d]), $sformatf("source %0d ready", rs));
            end else begin
               chk(!(dst_v(d) && qpre[d] == 0), "R5", 32'(dst_v(d)), 0,
                   $sformatf("dest %0d valid before a word was staged", d));
            end
            if (dst_v(d) && rr[d]) begin
               if (q[d].size() == 0) begin
                  chk(0, "R8", 32'(dst_d(d)), 0, $sformatf("dest %0d delivered unexpected word", d));
               end else begin
                  logic [DW-1:0] e;
                  e = q[d].pop_front();
                  chk(dst_d(d) == e, unp ? "R4" : "R5", 32'(dst_d(d)), 32'(e), $sformatf("dest %0d data", d));
                  if (tp_on) tp_count[d]++;
               end
            end
            if (!unp) chk(q[d].size() <= 2, "R5", q[d].size(), 2, $sformatf("dest %0d words in flight", d));
         end
      end
   endtask

   task automatic cycle();
      @(negedge clk);
      drive();
      #1;
      sample();
   endtask

   task automatic clear_routes();
      pend_cfg = '0;
      for (int i = 0; i < 10; i++) next_src[i] = -1;
   endtask

   task automatic route(int d, int s);
      logic [31:0] code;
      next_src[d] = s;
      if (d < 8) begin
         code = (s < 8) ? 32'(s - (d / 4) * 4 + 1) : 32'(5 + s - 8);
         pend_cfg = pend_cfg | (code << (3 * d));
      end else begin
         code = 32'(8 | s);
         pend_cfg = pend_cfg | (code << (24 + 4 * (d - 8)));
      end
   endtask

   task automatic commit_routes();
      for (int i = 0; i < 10; i++) route_dst[i] = -1;
      for (int d = 0; d < 10; d++) begin
         route_src[d] = next_src[d];
         if (next_src[d] >= 0) route_dst[next_src[d]] = d;
      end
   endtask

   task automatic load_cfg(bit probe);
      vp = 0; rp = 0;
      if (probe) begin
         sv[3] = 1; sd[3] = 16'h3ABC; acc[3] = 0;
      end
      @(negedge clk);
      drive();
      cfg_load = 1'b1;
      cfg_word = pend_cfg;
      #1;
      sample();
      if (probe) chk(lout_valid[1] == 1'b0, "R9", 32'(lout_valid[1]), 0, "route visible in load cycle");
      @(negedge clk);
      cfg_load = 1'b0;
      commit_routes();
      drive();
      #1;
      sample();
      if (probe) begin
         chk(lout_valid[1] == 1'b1, "R9", 32'(lout_valid[1]), 1, "route active after load edge");
         chk(lout_data[1] == 16'h3ABC, "R9", 32'(lout_data[1]), 32'h3ABC, "routed data after load");
      end
   endtask

   task automatic run_phases();
      vp = 100; rp = 100;
      for (int i = 0; i < 10; i++) tp_count[i] = 0;
      repeat (5) cycle();
      tp_on = 1;
      repeat (20) cycle();
      tp_on = 0;
      for (int d = 0; d < 10; d++)
         if (route_src[d] >= 0)
            chk(tp_count[d] == 20, "R6", tp_count[d], 20, $sformatf("dest %0d words in 20 cycles", d));
      vp = 60; rp = 50;
      repeat (300) cycle();
      vp = 30; rp = 90;
      repeat (200) cycle();
      vp = 0; rp = 100;
      repeat (12) cycle();
      for (int d = 0; d < 10; d++)
         chk(q[d].size() == 0, "R5", q[d].size(), 0, $sformatf("dest %0d undelivered words after drain", d));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog expired t=%0t", $time);
      finish_run();
   end

   initial begin
      tp_on = 0;
      vp = 0; rp = 0;
      for (int i = 0; i < 10; i++) begin
         sv[i] = 0; sd[i] = '0; rr[i] = 0; acc[i] = 0; seq[i] = 0;
      end
      clear_routes();
      commit_routes();
      repeat (3) cycle();
      // R1 during reset
      chk(lout_valid == 8'h00 && core_rx_valid == 2'b00, "R1",
          {22'd0, lout_valid, core_rx_valid}, 0, "valid in reset");
      chk(lin_ready == 8'h00 && core_tx_ready == 2'b00, "R1",
          {22'd0, lin_ready, core_tx_ready}, 0, "ready in reset");
      @(negedge clk);
      rst_n = 1'b1;
      vp = 100; rp = 100;
      drive();
      #1;
      sample();
      // R1 first cycle after reset: nothing routed although all sources offer
      chk(lout_valid == 8'h00 && core_rx_valid == 2'b00, "R1",
          {22'd0, lout_valid, core_rx_valid}, 0, "valid after reset");
      chk(lin_ready == 8'h00 && core_tx_ready == 2'b00, "R1",
          {22'd0, lin_ready, core_tx_ready}, 0, "ready after reset");
      vp = 0; rp = 0;
      for (int i = 0; i < 10; i++) sv[i] = 0;
      cycle();

      // Configuration A
      clear_routes();
      route(1, 3);   // E0 <- W0 input, plain
      route(2, 9);   // S0 <- core stream 1, plain
      route(4, 8);   // N1 <- core stream 0, staged
      route(7, 5);   // W1 <- E1 input, staged
      route(8, 6);   // core input 0 <- S1 input
      route(9, 0);   // core input 1 <- N0 input
      load_cfg(1);
      run_phases();

      // Configuration B, with output 1 set to code 7 (off)
      clear_routes();
      route(0, 2);   // N0 <- S0 input, plain
      route(3, 8);   // W0 <- core stream 0, plain
      route(5, 9);   // E1 <- core stream 1, staged
      route(6, 4);   // S1 <- N1 input, staged
      route(8, 7);   // core input 0 <- W1 input
      route(9, 1);   // core input 1 <- E0 input
      pend_cfg = pend_cfg | (32'd7 << 3);
      load_cfg(0);
      run_phases();

      finish_run();
   end
endmodule